// File: doc/BRIEF.md
# Protection Unit Region Register File

This block is the software-visible register file of a memory protection unit. Software reaches it over a simple word-wide bus that has single-cycle read and write strobes. It holds a control word, a region selector and, for each implemented region, a base word and an attribute word. The attribute word carries the size, the enable and the access attributes. The base and attribute registers are reached indirectly: the selector picks which region a bus access touches. The same base and attribute registers also appear at several alias offsets. A base write can carry its own region index, which also moves the selector.

The stored region arrays go out in parallel to the permission checker. An update pulse tells that checker that a region word changed, so it can drop any cached decision. Selector values that are out of range are refused, and accesses through an out-of-range selector are inert.

Top module: `mpu_regfile`

## Requirements
- R1: While `rst_n` is low at a clock edge, the control word, the selector, every region base and attribute word, `rd_data` and `upd_pulse` are all cleared to 0.
- R2: Offset 0xD94 holds the control word. A write keeps the low `CTRL_W` bits of the data, and a read returns them zero-extended.
- R3: Offset 0xD98 is the region selector. A write with a value below `NUM_RGN` stores that value, and a read returns it.
- R4: A selector write with a value of `NUM_RGN` or more is ignored, and the selector keeps its previous value.
- R5: The base register appears at offsets 0xD9C, 0xDA4, 0xDAC and 0xDB4. A write with data bit 4 clear stores data bits 31:5 into the selected region. A read returns those bits with bits 4:0 as zero.
- R6: The attribute register appears at offsets 0xDA0, 0xDA8, 0xDB0 and 0xDB8. It stores and returns the whole 32-bit word of the selected region.
- R7: A base write with data bit 4 set takes its region from data bits 3:0. It writes that region's base and sets the selector to that index.
- R8: A base write with data bit 4 set and an index of `NUM_RGN` or more changes nothing: not the selector, not any region, and no update pulse.
- R9: Read data is registered. It appears in the cycle after the read strobe and holds until the next read. Unmapped or unaligned offsets read as 0.
- R10: `upd_pulse` is high for exactly the one cycle after an accepted base or attribute write. It stays low after control writes, selector writes and ignored writes.
- R11: Slice i of `rgn_base` and of `rgn_attr` shows region i's stored base (bits 4:0 zero) and attribute word. A change is visible in the cycle after the write strobe.
- R12: Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | ADDR_W | Byte offset of the access |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| ctrl_word | output | CTRL_W | Stored control bits |
| rgn_base | output | NUM_RGN*32 | Base words of all regions, region 0 in the low slice |
| rgn_attr | output | NUM_RGN*32 | Attribute words of all regions, region 0 in the low slice |
| upd_pulse | output | 1 | One-cycle pulse after a region word changed |

## Verification
Every result of this block is due exactly one clock edge after its strobe. Read data, the update pulse, the region arrays and the selector all settle at the edge that samples the strobe. The bench drives each operation at a falling edge and lets one rising edge pass. It then compares the outputs at the next falling edge against a model that was updated at that same point. Before any read it brings the selector and the arrays out through the bus, so refused writes can be shown to have had no effect.

// File: rtl/mpu_regfile_pkg.sv
// Shared types and offsets of the protection unit region register file.
// Assumes byte offsets on a word-wide bus; aliases are spaced 8 bytes apart.
package mpu_regfile_pkg;

    typedef enum logic [2:0] {
        K_NONE = 3'd0,
        K_CTRL = 3'd1,
        K_SEL  = 3'd2,
        K_BASE = 3'd3,
        K_ATTR = 3'd4
    } reg_kind_e;

    localparam logic [11:0] OFS_CTRL      = 12'hD94;
    localparam logic [11:0] OFS_SEL       = 12'hD98;
    localparam logic [11:0] OFS_BASE0     = 12'hD9C;
    localparam logic [11:0] OFS_ATTR0     = 12'hDA0;
    localparam int          ALIAS_STEP    = 8;
    localparam int          ALIAS_COUNT   = 4;

endpackage

// File: rtl/mpu_addr_decode.sv
// Classifies a bus offset into one of the register kinds.
// Assumes the offset is a byte address; any unaligned offset is K_NONE.
module mpu_addr_decode
    import mpu_regfile_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind
);

    logic [ALIAS_COUNT-1:0] base_hit;
    logic [ALIAS_COUNT-1:0] attr_hit;

    // One comparator pair per alias slot
    for (genvar k = 0; k < ALIAS_COUNT; k++) begin : g_alias
        assign base_hit[k] = (addr == ADDR_W'(int'(OFS_BASE0) + k * ALIAS_STEP));
        assign attr_hit[k] = (addr == ADDR_W'(int'(OFS_ATTR0) + k * ALIAS_STEP));
    end

    // Priority-free selection; the hit sets are disjoint
    always_comb begin
        kind = K_NONE;
        if (addr == ADDR_W'(OFS_CTRL))     kind = K_CTRL;
        else if (addr == ADDR_W'(OFS_SEL)) kind = K_SEL;
        else if (|base_hit)                kind = K_BASE;
        else if (|attr_hit)                kind = K_ATTR;
    end

endmodule

// File: rtl/mpu_region_bank.sv
// Per-region base and attribute storage with a parallel view for the checker.
// Assumes at most one write per cycle and a write index already range-checked
// by the caller; the read port returns 0 for an index outside the bank.
module mpu_region_bank #(
    parameter int NUM_RGN = 8,
    parameter int IDX_W   = 4,
    parameter int BASE_LO = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we_base,
    input  logic                    we_attr,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [31:0]             wr_word,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic [31:0]             rd_base,
    output logic [31:0]             rd_attr,
    output logic [NUM_RGN*32-1:0]   base_flat,
    output logic [NUM_RGN*32-1:0]   attr_flat
);

    logic [31:0] base_q [NUM_RGN];
    logic [31:0] attr_q [NUM_RGN];

    for (genvar i = 0; i < NUM_RGN; i++) begin : g_rgn
        // Store one region's words; clear both on reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[i] <= '0;
                attr_q[i] <= '0;
            end else begin
                if (we_base && wr_idx == IDX_W'(i))
                    base_q[i] <= {wr_word[31:BASE_LO], BASE_LO'(0)};
                if (we_attr && wr_idx == IDX_W'(i))
                    attr_q[i] <= wr_word;
            end
        end
        assign base_flat[i*32 +: 32] = base_q[i];
        assign attr_flat[i*32 +: 32] = attr_q[i];
    end

    // Indexed read with an out-of-range guard
    always_comb begin
        rd_base = '0;
        rd_attr = '0;
        for (int i = 0; i < NUM_RGN; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_base = base_q[i];
                rd_attr = attr_q[i];
            end
        end
    end

endmodule

// File: rtl/mpu_regfile.sv
// Register file of the protection unit: control word, region selector and
// indirectly indexed per-region base/attribute words with alias offsets.
// Assumes single-cycle strobes, never wr_en and rd_en together on one address
// expecting new data (a read returns the value before a same-cycle write).
module mpu_regfile
    import mpu_regfile_pkg::*;
#(
    parameter int NUM_RGN = 8,
    parameter int IDX_W   = 4,
    parameter int ADDR_W  = 12,
    parameter int CTRL_W  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [31:0]           wr_data,
    output logic [31:0]           rd_data,
    output logic [CTRL_W-1:0]     ctrl_word,
    output logic [NUM_RGN*32-1:0] rgn_base,
    output logic [NUM_RGN*32-1:0] rgn_attr,
    output logic                  upd_pulse
);

    localparam int DIRECT_BIT = IDX_W;
    localparam int BASE_LO    = IDX_W + 1;

    reg_kind_e         kind;
    logic [IDX_W-1:0]  sel_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [IDX_W-1:0]  wr_idx;
    logic              idx_ok;
    logic              direct;
    logic              we_base;
    logic              we_attr;
    logic              sel_load;
    logic [IDX_W-1:0]  sel_d;
    logic [31:0]       bank_base;
    logic [31:0]       bank_attr;
    logic [31:0]       rd_next;

    mpu_addr_decode #(.ADDR_W(ADDR_W)) dec_i (
        .addr (addr),
        .kind (kind)
    );

    // Resolve the target region and whether a write is accepted
    always_comb begin
        direct   = (kind == K_BASE) && wr_data[DIRECT_BIT];
        wr_idx   = direct ? wr_data[IDX_W-1:0] : sel_q;
        idx_ok   = (32'(wr_idx) < 32'(NUM_RGN));
        we_base  = wr_en && (kind == K_BASE) && idx_ok;
        we_attr  = wr_en && (kind == K_ATTR) && idx_ok;
        sel_load = 1'b0;
        sel_d    = sel_q;
        if (wr_en && kind == K_SEL && wr_data < 32'(NUM_RGN)) begin
            sel_load = 1'b1;
            sel_d    = wr_data[IDX_W-1:0];
        end else if (we_base && direct) begin
            sel_load = 1'b1;
            sel_d    = wr_idx;
        end
    end

    // Selector, control word and update pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q     <= '0;
            ctrl_q    <= '0;
            upd_pulse <= 1'b0;
        end else begin
            if (sel_load) sel_q <= sel_d;
            if (wr_en && kind == K_CTRL) ctrl_q <= wr_data[CTRL_W-1:0];
            upd_pulse <= we_base || we_attr;
        end
    end

    mpu_region_bank #(
        .NUM_RGN (NUM_RGN),
        .IDX_W   (IDX_W),
        .BASE_LO (BASE_LO)
    ) bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_base   (we_base),
        .we_attr   (we_attr),
        .wr_idx    (wr_idx),
        .wr_word   (wr_data),
        .rd_idx    (sel_q),
        .rd_base   (bank_base),
        .rd_attr   (bank_attr),
        .base_flat (rgn_base),
        .attr_flat (rgn_attr)
    );

    // Read multiplexer by register kind
    always_comb begin
        unique case (kind)
            K_CTRL:  rd_next = 32'(ctrl_q);
            K_SEL:   rd_next = 32'(sel_q);
            K_BASE:  rd_next = bank_base;
            K_ATTR:  rd_next = bank_attr;
            default: rd_next = '0;
        endcase
    end

    // Registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end

    assign ctrl_word = ctrl_q;

endmodule

// File: rtl/mpu_regfile_chk.sv
// Assertion checker for mpu_regfile, attached by bind below.
// Assumes the selector is brought in from the top's internal register.
module mpu_regfile_chk #(
    parameter int NUM_RGN = 8,
    parameter int IDX_W   = 4,
    parameter int ADDR_W  = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic                  rd_en,
    input logic [ADDR_W-1:0]     addr,
    input logic [31:0]           rd_data,
    input logic                  upd_pulse,
    input logic [IDX_W-1:0]      sel,
    input logic [NUM_RGN*32-1:0] rgn_base,
    input logic [NUM_RGN*32-1:0] rgn_attr
);

    // R1: first cycle out of reset sees cleared outputs
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rd_data == 32'd0 && !upd_pulse && sel == '0));

    // R4: the selector never holds an unimplemented region
    a_r4_sel_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        32'(sel) < 32'(NUM_RGN));

    // R9: unmapped or unaligned reads return zero
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_en) && ($past(addr) < ADDR_W'(12'hD94) || $past(addr) > ADDR_W'(12'hDB8)
                          || $past(addr[1:0]) != 2'b00)) |-> rd_data == 32'd0);

    // R10: an update pulse only follows a write
    a_r10_pulse_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |-> $past(wr_en));

    // R11: region arrays move only after a write
    a_r11_arrays_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> ($stable(rgn_base) && $stable(rgn_attr)));

    // R9: read data holds when no read was issued
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> $stable(rd_data));

endmodule

bind mpu_regfile mpu_regfile_chk #(
    .NUM_RGN (NUM_RGN),
    .IDX_W   (IDX_W),
    .ADDR_W  (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .rd_data   (rd_data),
    .upd_pulse (upd_pulse),
    .sel       (sel_q),
    .rgn_base  (rgn_base),
    .rgn_attr  (rgn_attr)
);

// File: tb/mpu_regfile_tb_top.sv
module mpu_regfile_tb_top;

    localparam int NUM_RGN = 8;
    localparam int ADDR_W  = 12;
    localparam int CTRL_W  = 3;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  wr_en = 1'b0;
    logic                  rd_en = 1'b0;
    logic [ADDR_W-1:0]     addr = '0;
    logic [31:0]           wr_data = '0;
    logic [31:0]           rd_data;
    logic [CTRL_W-1:0]     ctrl_word;
    logic [NUM_RGN*32-1:0] rgn_base;
    logic [NUM_RGN*32-1:0] rgn_attr;
    logic                  upd_pulse;

    int n_run  = 0;
    int n_fail = 0;

    logic [31:0] m_base [NUM_RGN];
    logic [31:0] m_attr [NUM_RGN];
    logic [31:0] m_ctrl;
    logic [31:0] m_sel;
    logic        m_upd;

    always #2 clk = ~clk;

    mpu_regfile #(.NUM_RGN(NUM_RGN), .IDX_W(4), .ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) dut_i (
        .clk, .rst_n, .wr_en, .rd_en, .addr, .wr_data, .rd_data,
        .ctrl_word, .rgn_base, .rgn_attr, .upd_pulse
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit is_base(input logic [11:0] a);
        return a == 12'hD9C || a == 12'hDA4 || a == 12'hDAC || a == 12'hDB4;
    endfunction

    function automatic bit is_attr(input logic [11:0] a);
        return a == 12'hDA0 || a == 12'hDA8 || a == 12'hDB0 || a == 12'hDB8;
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        if (a == 12'hD94) return m_ctrl;
        if (a == 12'hD98) return m_sel;
        if (is_base(a))   return (m_sel < NUM_RGN) ? m_base[m_sel] : 32'd0;
        if (is_attr(a))   return (m_sel < NUM_RGN) ? m_attr[m_sel] : 32'd0;
        return 32'd0;
    endfunction

    // Model of a write per R2..R8, R10, R12
    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        m_upd = 1'b0;
        if (a == 12'hD94) m_ctrl = {29'd0, d[2:0]};
        else if (a == 12'hD98) begin
            if (d < NUM_RGN) m_sel = d;
        end else if (is_base(a)) begin
            logic [31:0] idx;
            idx = d[4] ? {28'd0, d[3:0]} : m_sel;
            if (idx < NUM_RGN) begin
                m_base[idx] = {d[31:5], 5'd0};
                if (d[4]) m_sel = idx;
                m_upd = 1'b1;
            end
        end else if (is_attr(a)) begin
            if (m_sel < NUM_RGN) begin
                m_attr[m_sel] = d;
                m_upd = 1'b1;
            end
        end
    endtask

    task automatic check_arrays(input string req);
        for (int i = 0; i < NUM_RGN; i++) begin
            check(rgn_base[i*32 +: 32] == m_base[i], req, rgn_base[i*32 +: 32], m_base[i]);
            check(rgn_attr[i*32 +: 32] == m_attr[i], req, rgn_attr[i*32 +: 32], m_attr[i]);
        end
        check(32'(ctrl_word) == m_ctrl, req, 32'(ctrl_word), m_ctrl);
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d, input string req);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        model_write(a, d);
        @(negedge clk);
        wr_en = 1'b0;
        check(upd_pulse == m_upd, {req, " R10 pulse"}, 32'(upd_pulse), 32'(m_upd));
        check_arrays({req, " R11 arrays"});
    endtask

    task automatic do_read(input logic [11:0] a, input string req);
        logic [31:0] e;
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        e = exp_read(a);
        @(negedge clk);
        rd_en = 1'b0;
        check(rd_data == e, req, rd_data, e);
    endtask

    // Watchdog: a hung run is a failure and still summarises
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [11:0] maps [10];
        maps = '{12'hD94, 12'hD98, 12'hD9C, 12'hDA0, 12'hDA4,
                 12'hDA8, 12'hDAC, 12'hDB0, 12'hDB4, 12'hDB8};
        void'($urandom(32'h5EED));
        for (int i = 0; i < NUM_RGN; i++) begin m_base[i] = 0; m_attr[i] = 0; end
        m_ctrl = 0; m_sel = 0; m_upd = 0;

        // Dirty the state, then apply reset (R1)
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b1; addr = 12'hDA0; wr_data = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        wr_en = 1'b0;
        rst_n = 1'b1;
        check(rd_data == 0, "R1 rd_data", rd_data, 0);
        check(upd_pulse == 0, "R1 pulse", 32'(upd_pulse), 0);
        check_arrays("R1 arrays");
        do_read(12'hD98, "R1 selector");

        // Directed cases
        do_write(12'hD94, 32'hFFFF_FFFD, "R2 ctrl");
        do_read(12'hD94, "R2 ctrl read");
        do_write(12'hD98, 32'd5, "R3 sel");
        do_read(12'hD98, "R3 sel read");
        do_write(12'hD98, 32'd8, "R4 sel=N");
        do_read(12'hD98, "R4 sel kept");
        do_write(12'hD98, 32'hFFFF_FFFF, "R4 sel huge");
        do_read(12'hD98, "R4 sel kept 2");
        do_write(12'hDB4, 32'hABCD_1263, "R5 base alias bit4 clear");
        do_read(12'hD9C, "R5 base read");
        do_write(12'hDB8, 32'h1234_5678, "R6 attr alias");
        do_read(12'hDA0, "R6 attr read");
        do_write(12'hD9C, 32'hCAFE_0017, "R7 direct idx7");
        do_read(12'hD98, "R7 sel moved");
        do_read(12'hDAC, "R7 base read");
        do_write(12'hDA4, 32'h7777_001A, "R8 direct idx10 ignored");
        do_read(12'hD98, "R8 sel kept");
        do_write(12'hD90, 32'hFFFF_FFFF, "R12 unmapped");
        do_write(12'hD95, 32'hFFFF_FFFF, "R12 unaligned");
        do_read(12'hD94, "R12 ctrl kept");
        do_read(12'hDBC, "R9 unmapped read");
        do_read(12'hD96, "R9 unaligned read");

        // Random mix of mapped and unmapped accesses
        for (int n = 0; n < 400; n++) begin
            int pick;
            logic [11:0] a;
            logic [31:0] d;
            pick = int'($urandom % 12);
            if (pick < 10) a = maps[pick];
            else           a = 12'(12'hC00 + ($urandom % 12'h300));
            if (a == 12'hD98) d = $urandom % (NUM_RGN + 4);
            else if (is_base(a)) d = {$urandom % 32'h0800_0000, 1'b0, 4'(0)} | (32'($urandom % 2) << 4) | 32'($urandom % 16);
            else d = $urandom;
            if ($urandom % 2 == 0) do_write(a, d, "R5-mix random write");
            else                   do_read(a, "R9 random read");
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule